// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Controller

This block is the command front end and status logic of a small serial flash slave on an SPI link (mode 0). It oversamples the serial clock, chip select, data-in and write-protect pins in the system clock domain. It decodes an 8-bit opcode that arrives MSB first while chip select is low. It keeps the status byte, which holds the write-enable latch, the busy flag, two block-protect bits and a status-write-disable bit. It returns that byte on the serial output, MSB first. The byte repeats for as long as chip select stays low.

Program and erase requests do not reach a memory array here. The block turns each one into a single-cycle grant or deny decision, with the operation kind and the full address beside it. It bases that decision on the write-enable latch, the protected address region and the busy flag. When a status write, program or erase is accepted, a busy timer of `BUSY_CLKS` system clocks starts. While it runs, the block refuses every command except status reads. When it expires, the busy flag and the write-enable latch both clear.

The command state machine has seven states:
- `ST_IDLE`: chip select is high.
- `ST_OPCODE`: the opcode is being shifted in.
- `ST_STATOUT`: the status byte is streaming out.
- `ST_PAYLOAD`: the data byte of a status write is arriving.
- `ST_ADDR`: the address bytes are arriving.
- `ST_TAIL`: the command is complete and waits for deselect. Program data bytes may follow in this state.
- `ST_DISCARD`: the command is ignored until deselect.

The transitions are:
- `ST_IDLE` goes to `ST_OPCODE` when chip select falls.
- `ST_OPCODE` goes to `ST_STATOUT` on a status-read opcode.
- `ST_OPCODE` goes to `ST_DISCARD` on an unknown opcode, or on any other opcode while busy.
- `ST_OPCODE` goes to `ST_PAYLOAD` on a status write.
- `ST_OPCODE` goes to `ST_ADDR` on a page program or sector erase.
- `ST_OPCODE` goes to `ST_TAIL` on enable, disable or bulk erase.
- `ST_PAYLOAD` goes to `ST_TAIL` after one byte.
- `ST_ADDR` goes to `ST_TAIL` after `ADDR_BYTES` bytes.
- `ST_TAIL` goes to `ST_DISCARD` on any further bit, unless the command is a page program.
- Every state returns to `ST_IDLE` when chip select is high.

Top module: `sfs_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00. `spi_miso_oe` is 0 while chip select is high and during the 8 opcode bits of a status read.
- R2: Opcode 0x05 streams the status byte MSB first. The layout is bit 7 = status-write-disable, bits 6..4 = 0, bits 3..2 = block protect (bit 3 high), bit 1 = write-enable latch and bit 0 = busy. The byte repeats for every further 8 clocks until chip select rises.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it.
- R4: Opcode 0x01 followed by one data byte copies data bit 7 into status bit 7 and data bits 3..2 into the block-protect bits. It has this effect only when the write-enable latch is 1; otherwise nothing changes.
- R5: An accepted status write, or a granted program or erase, sets busy in the same cycle as the grant. Busy stays set for `BUSY_CLKS` clocks, and then busy and the write-enable latch clear together.
- R6: While busy, every opcode except 0x05 is ignored, and a status read still works.
- R7: Page program (0x02) and sector erase (0xD8) carry `ADDR_BYTES` address bytes, MSB first. Their decision uses the top `ARRAY_AW` array-address bits, and the protected region sits at the top of the array. Block protect 01 protects addresses with the two top array bits equal to 11. Block protect 10 protects those with the top bit equal to 1. Block protect 11 protects all addresses, and 00 protects none. A request into the protected region pulses `op_deny`; otherwise it pulses `op_grant`. `op_kind` reads 0 for a program and 1 for a sector erase, and `op_addr` carries the address.
- R8: Bulk erase (0xC7, `op_kind` 2) is granted only when both block-protect bits are 0, and is denied otherwise.
- R9: When status bit 7 is 1 and `wp_n` is low, a status write is rejected and the protect bits and bit 7 cannot change. With `wp_n` high the same write is accepted.
- R10: A command takes effect only if chip select rises after a whole number of bytes. A cut-short opcode, extra bits after an enable or disable, or a partial program data byte leaves the status unchanged and produces no grant or deny.
- R11: A program or erase while the write-enable latch is 0 pulses `op_deny` and does not set busy. A grant is never issued unless the latch was 1 and busy was 0 in the preceding cycle. A deny leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in, sampled on serial clock rise |
| wp_n | input | 1 | Write-protect pin, active low |
| spi_miso | output | 1 | Serial data out, changes after serial clock fall |
| spi_miso_oe | output | 1 | Output enable for spi_miso (0 = high impedance) |
| op_grant | output | 1 | One-cycle pulse: program or erase accepted |
| op_deny | output | 1 | One-cycle pulse: program or erase refused |
| op_kind | output | 2 | 0 page program, 1 sector erase, 2 bulk erase |
| op_addr | output | 24 | Address of the decided request |

## Verification
Each pin passes through one sampling register and then an edge detector. A serial data-out bit therefore changes two system clocks after the serial clock falls at the pin. A grant, deny or status change appears three clocks after chip select rises at the pin, and busy starts in that same cycle. The bench holds every serial clock phase for five system clocks and reads `spi_miso` at the end of the low phase. It waits eight clocks after deselect before it issues the next transaction or reads the grant counters. For the busy interval it reads the status byte about 160 clocks into a 600-clock timer, so busy must still read 1. It reads it again after the full interval plus margin, so busy must read 0.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_WRDI = 8'h04;
    localparam logic [7:0] OPC_RDSR = 8'h05;
    localparam logic [7:0] OPC_WRSR = 8'h01;
    localparam logic [7:0] OPC_PP   = 8'h02;
    localparam logic [7:0] OPC_SE   = 8'hD8;
    localparam logic [7:0] OPC_BE   = 8'hC7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_STATOUT,
        ST_PAYLOAD,
        ST_ADDR,
        ST_TAIL,
        ST_DISCARD
    } fsm_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_RDSR,
        CMD_WREN,
        CMD_WRDI,
        CMD_WRSR,
        CMD_PP,
        CMD_SE,
        CMD_BE
    } cmd_e;

    localparam logic [1:0] KIND_PP = 2'd0;
    localparam logic [1:0] KIND_SE = 2'd1;
    localparam logic [1:0] KIND_BE = 2'd2;

    function automatic cmd_e decode_opc(input logic [7:0] opc);
        cmd_e c;
        case (opc)
            OPC_WREN: c = CMD_WREN;
            OPC_WRDI: c = CMD_WRDI;
            OPC_RDSR: c = CMD_RDSR;
            OPC_WRSR: c = CMD_WRSR;
            OPC_PP:   c = CMD_PP;
            OPC_SE:   c = CMD_SE;
            OPC_BE:   c = CMD_BE;
            default:  c = CMD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sfs_spi_front.sv
module sfs_spi_front
    import sfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              mosi_i,
    input  logic              wp_n_i,
    output logic              cs_s,
    output logic              wp_s,
    output logic              sclk_rise,
    output logic              sclk_fall,
    output logic              cs_rise,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic              aligned
);

    localparam int CNT_W = $clog2(BYTE_W);

    logic             sclk_s;
    logic             sclk_q;
    logic             cs_q;
    logic             mosi_s;
    logic [CNT_W-1:0] bit_cnt;
    logic [BYTE_W-2:0] shreg;

    // one sampling stage for every pin, one more for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_s <= 1'b0;
            sclk_q <= 1'b0;
            cs_s   <= 1'b1;
            cs_q   <= 1'b1;
            mosi_s <= 1'b0;
            wp_s   <= 1'b1;
        end else begin
            sclk_s <= sclk_i;
            sclk_q <= sclk_s;
            cs_s   <= cs_n_i;
            cs_q   <= cs_s;
            mosi_s <= mosi_i;
            wp_s   <= wp_n_i;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_q & ~cs_s;
    assign sclk_fall = ~sclk_s & sclk_q & ~cs_s;
    assign cs_rise   = cs_s & ~cs_q;

    // bit counter and shift register; the counter clears while deselected
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (cs_s) begin
            bit_cnt <= '0;
        end else if (sclk_rise) begin
            shreg   <= {shreg[BYTE_W-3:0], mosi_s};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign byte_val  = {shreg, mosi_s};
    assign byte_done = sclk_rise && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign aligned   = (bit_cnt == '0);

endmodule

// File: rtl/sfs_cmd_fsm.sv
module sfs_cmd_fsm
    import sfs_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    localparam int ADDR_W    = ADDR_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              cs_rise,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              aligned,
    input  logic              wip,
    input  logic [BYTE_W-1:0] status_i,
    output logic              commit,
    output cmd_e              commit_cmd,
    output logic [BYTE_W-1:0] commit_data,
    output logic [ADDR_W-1:0] commit_addr,
    output logic              miso,
    output logic              miso_oe
);

    localparam int ABC_W = $clog2(ADDR_BYTES + 1);
    localparam int IDX_W = $clog2(BYTE_W);

    fsm_e              state;
    fsm_e              nstate;
    cmd_e              dec;
    cmd_e              cmd_q;
    logic [ABC_W-1:0]  abyte_cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] data_q;
    logic [IDX_W-1:0]  out_idx;

    assign dec = decode_opc(byte_val);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // next-state logic
    always_comb begin
        nstate = state;
        if (cs_s) begin
            nstate = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nstate = ST_OPCODE;
                ST_OPCODE: begin
                    if (byte_done) begin
                        if (dec == CMD_RDSR)                    nstate = ST_STATOUT;
                        else if (wip || dec == CMD_NONE)        nstate = ST_DISCARD;
                        else if (dec == CMD_WRSR)               nstate = ST_PAYLOAD;
                        else if (dec == CMD_PP || dec == CMD_SE) nstate = ST_ADDR;
                        else                                    nstate = ST_TAIL;
                    end
                end
                ST_STATOUT: nstate = ST_STATOUT;
                ST_PAYLOAD: if (byte_done) nstate = ST_TAIL;
                ST_ADDR: begin
                    if (byte_done && abyte_cnt == ABC_W'(ADDR_BYTES - 1))
                        nstate = ST_TAIL;
                end
                ST_TAIL: if (sclk_rise && cmd_q != CMD_PP) nstate = ST_DISCARD;
                ST_DISCARD: nstate = ST_DISCARD;
            endcase
        end
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit    <= 1'b0;
            cmd_q     <= CMD_NONE;
            abyte_cnt <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            out_idx   <= '0;
            miso      <= 1'b0;
            miso_oe   <= 1'b0;
        end else begin
            commit <= cs_rise && (state == ST_TAIL) && aligned;

            if (state == ST_OPCODE && byte_done) begin
                cmd_q     <= dec;
                abyte_cnt <= '0;
                out_idx   <= IDX_W'(BYTE_W - 1);
            end
            if (state == ST_PAYLOAD && byte_done) begin
                data_q <= byte_val;
            end
            if (state == ST_ADDR && byte_done) begin
                addr_q    <= (addr_q << BYTE_W) | ADDR_W'(byte_val);
                abyte_cnt <= abyte_cnt + 1'b1;
            end

            if (cs_s) begin
                miso_oe <= 1'b0;
            end else if (state == ST_STATOUT && sclk_fall) begin
                miso    <= status_i[out_idx];
                miso_oe <= 1'b1;
                out_idx <= out_idx - 1'b1;
            end
        end
    end

    assign commit_cmd  = cmd_q;
    assign commit_data = data_q;
    assign commit_addr = addr_q;

endmodule

// File: rtl/sfs_prot_region.sv
module sfs_prot_region #(
    parameter int AW = 18
) (
    input  logic [1:0]    bp,
    input  logic [AW-1:0] addr,
    output logic          hit
);

    always_comb begin
        unique case (bp)
            2'b00: hit = 1'b0;
            2'b01: hit = &addr[AW-1:AW-2];
            2'b10: hit = addr[AW-1];
            2'b11: hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/sfs_status_core.sv
module sfs_status_core
    import sfs_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int BUSY_CLKS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  cmd_e              commit_cmd,
    input  logic [BYTE_W-1:0] commit_data,
    input  logic [ADDR_W-1:0] commit_addr,
    input  logic              prot_hit,
    input  logic              wp_s,
    output logic              srwd,
    output logic [1:0]        bp,
    output logic              wel,
    output logic              wip,
    output logic [BYTE_W-1:0] status_byte,
    output logic              op_grant,
    output logic              op_deny,
    output logic [1:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr
);

    localparam int BUSY_W = $clog2(BUSY_CLKS + 1);

    logic [BUSY_W-1:0] busy_cnt;
    logic              hw_locked;

    assign hw_locked   = srwd & ~wp_s;
    assign wip         = (busy_cnt != '0);
    assign status_byte = {srwd, 3'b000, bp, wel, wip};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srwd     <= 1'b0;
            bp       <= 2'b00;
            wel      <= 1'b0;
            busy_cnt <= '0;
            op_grant <= 1'b0;
            op_deny  <= 1'b0;
            op_kind  <= KIND_PP;
            op_addr  <= '0;
        end else begin
            op_grant <= 1'b0;
            op_deny  <= 1'b0;

            if (busy_cnt != '0) begin
                busy_cnt <= busy_cnt - 1'b1;
                if (busy_cnt == BUSY_W'(1)) wel <= 1'b0;
            end

            if (commit && !wip) begin
                unique case (commit_cmd)
                    CMD_WREN: wel <= 1'b1;
                    CMD_WRDI: wel <= 1'b0;
                    CMD_WRSR: begin
                        if (wel && !hw_locked) begin
                            srwd     <= commit_data[7];
                            bp       <= commit_data[3:2];
                            busy_cnt <= BUSY_W'(BUSY_CLKS);
                        end
                    end
                    CMD_PP, CMD_SE: begin
                        op_kind <= (commit_cmd == CMD_PP) ? KIND_PP : KIND_SE;
                        op_addr <= commit_addr;
                        if (wel && !prot_hit) begin
                            op_grant <= 1'b1;
                            busy_cnt <= BUSY_W'(BUSY_CLKS);
                        end else begin
                            op_deny <= 1'b1;
                        end
                    end
                    CMD_BE: begin
                        op_kind <= KIND_BE;
                        op_addr <= '0;
                        if (wel && bp == 2'b00) begin
                            op_grant <= 1'b1;
                            busy_cnt <= BUSY_W'(BUSY_CLKS);
                        end else begin
                            op_deny <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sfs_status_ctrl.sv
module sfs_status_ctrl
    import sfs_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int ARRAY_AW   = 18,
    parameter int BUSY_CLKS  = 1000,
    localparam int ADDR_W    = ADDR_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    input  logic              wp_n,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              op_grant,
    output logic              op_deny,
    output logic [1:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr
);

    logic              cs_s;
    logic              wp_s;
    logic              sclk_rise;
    logic              sclk_fall;
    logic              cs_rise;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic              aligned;
    logic              commit;
    cmd_e              commit_cmd;
    logic [BYTE_W-1:0] commit_data;
    logic [ADDR_W-1:0] commit_addr;
    logic              prot_hit;
    logic              srwd;
    logic [1:0]        bp;
    logic              wel;
    logic              wip;
    logic [BYTE_W-1:0] status_byte;

    sfs_spi_front u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (spi_sclk),
        .cs_n_i    (spi_cs_n),
        .mosi_i    (spi_mosi),
        .wp_n_i    (wp_n),
        .cs_s      (cs_s),
        .wp_s      (wp_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_rise   (cs_rise),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .aligned   (aligned)
    );

    sfs_cmd_fsm #(.ADDR_BYTES(ADDR_BYTES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_s        (cs_s),
        .cs_rise     (cs_rise),
        .sclk_rise   (sclk_rise),
        .sclk_fall   (sclk_fall),
        .byte_done   (byte_done),
        .byte_val    (byte_val),
        .aligned     (aligned),
        .wip         (wip),
        .status_i    (status_byte),
        .commit      (commit),
        .commit_cmd  (commit_cmd),
        .commit_data (commit_data),
        .commit_addr (commit_addr),
        .miso        (spi_miso),
        .miso_oe     (spi_miso_oe)
    );

    sfs_prot_region #(.AW(ARRAY_AW)) u_prot (
        .bp   (bp),
        .addr (commit_addr[ARRAY_AW-1:0]),
        .hit  (prot_hit)
    );

    sfs_status_core #(.ADDR_W(ADDR_W), .BUSY_CLKS(BUSY_CLKS)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .commit_cmd  (commit_cmd),
        .commit_data (commit_data),
        .commit_addr (commit_addr),
        .prot_hit    (prot_hit),
        .wp_s        (wp_s),
        .srwd        (srwd),
        .bp          (bp),
        .wel         (wel),
        .wip         (wip),
        .status_byte (status_byte),
        .op_grant    (op_grant),
        .op_deny     (op_deny),
        .op_kind     (op_kind),
        .op_addr     (op_addr)
    );

endmodule

// File: rtl/sfs_status_chk.sv
module sfs_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_s,
    input logic       wp_s,
    input logic       spi_miso_oe,
    input logic       wip,
    input logic       wel,
    input logic       srwd,
    input logic [1:0] bp,
    input logic       op_grant,
    input logic       op_deny
);

    assert_oe_off_when_deselected_R1: assert property (
        @(posedge clk) disable iff (!rst_n) cs_s |=> !spi_miso_oe);

    assert_grant_starts_busy_R5: assert property (
        @(posedge clk) disable iff (!rst_n) op_grant |-> wip);

    assert_busy_end_clears_wel_R5: assert property (
        @(posedge clk) disable iff (!rst_n) $fell(wip) |-> !wel);

    assert_no_grant_from_busy_R6: assert property (
        @(posedge clk) disable iff (!rst_n) op_grant |-> $past(!wip));

    assert_grant_deny_exclusive_R7: assert property (
        @(posedge clk) disable iff (!rst_n) !(op_grant && op_deny));

    assert_hw_lock_freezes_bits_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (srwd && !wp_s) |=> ($stable(srwd) && $stable(bp)));

    assert_grant_needs_wel_R11: assert property (
        @(posedge clk) disable iff (!rst_n) op_grant |-> $past(wel));

endmodule

bind sfs_status_ctrl sfs_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_s        (cs_s),
    .wp_s        (wp_s),
    .spi_miso_oe (spi_miso_oe),
    .wip         (wip),
    .wel         (wel),
    .srwd        (srwd),
    .bp          (bp),
    .op_grant    (op_grant),
    .op_deny     (op_deny)
);

// File: tb/tb_sfs_status_ctrl.sv
`timescale 1ns/1ps
module tb_sfs_status_ctrl;

    localparam int BUSY = 600;
    localparam int HALF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        wp_n = 1'b1;
    logic        spi_miso;
    logic        spi_miso_oe;
    logic        op_grant;
    logic        op_deny;
    logic [1:0]  op_kind;
    logic [23:0] op_addr;

    int checks = 0;
    int errors = 0;
    int n_grant = 0;
    int n_deny = 0;
    logic [1:0]  last_kind = 2'd3;
    logic [23:0] last_addr = '0;
    bit done = 0;

    always #4 clk = ~clk;

    sfs_status_ctrl #(.ADDR_BYTES(3), .ARRAY_AW(18), .BUSY_CLKS(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .wp_n(wp_n), .spi_miso(spi_miso),
        .spi_miso_oe(spi_miso_oe), .op_grant(op_grant), .op_deny(op_deny),
        .op_kind(op_kind), .op_addr(op_addr)
    );

    always @(posedge clk) begin
        if (op_grant) begin n_grant++; last_kind = op_kind; last_addr = op_addr; end
        if (op_deny)  begin n_deny++;  last_kind = op_kind; last_addr = op_addr; end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer_bit(input logic b, output logic mi, output logic oe);
        spi_mosi = b;
        repeat (HALF) @(negedge clk);
        mi = spi_miso;
        oe = spi_miso_oe;
        spi_sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        spi_sclk = 1'b0;
    endtask

    task automatic sel();
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic desel();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n, output logic any_oe);
        logic mi, oe;
        any_oe = 1'b0;
        for (int i = 7; i > 7 - n; i--) begin
            xfer_bit(v[i], mi, oe);
            any_oe |= oe;
        end
    endtask

    task automatic recv_byte(output logic [7:0] v);
        logic mi, oe;
        for (int i = 7; i >= 0; i--) begin
            xfer_bit(1'b0, mi, oe);
            v[i] = mi;
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic o;
        sel(); send_bits(op, 8, o); desel();
    endtask

    task automatic cmd2(input logic [7:0] op, input logic [7:0] d);
        logic o;
        sel(); send_bits(op, 8, o); send_bits(d, 8, o); desel();
    endtask

    task automatic cmd_addr(input logic [7:0] op, input logic [23:0] a, input int ndata);
        logic o;
        sel();
        send_bits(op, 8, o);
        send_bits(a[23:16], 8, o);
        send_bits(a[15:8], 8, o);
        send_bits(a[7:0], 8, o);
        for (int k = 0; k < ndata; k++) send_bits(8'hA5, 8, o);
        desel();
    endtask

    task automatic expect_status(input string tag, input logic [7:0] exp);
        logic [7:0] v;
        logic o;
        sel(); send_bits(8'h05, 8, o); recv_byte(v); desel();
        chk(tag, v, exp);
    endtask

    task automatic wait_busy();
        repeat (BUSY + 20) @(negedge clk);
    endtask

    task automatic expect_decision(input string tag, input int g0, input int d0,
                                   input int dg, input int dd,
                                   input logic [1:0] kind, input logic [23:0] addr);
        chk({tag, " grants"}, n_grant - g0, dg);
        chk({tag, " denies"}, n_deny - d0, dd);
        chk({tag, " kind"}, last_kind, kind);
        chk({tag, " addr"}, last_addr, addr);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        logic o;
        chk("R1 oe idle", spi_miso_oe, 1'b0);
        sel();
        send_bits(8'h05, 8, o);
        chk("R1 oe during opcode", o, 1'b0);
        recv_byte(v);
        desel();
        chk("R1 reset status", v, 8'h00);
        chk("R1 oe after deselect", spi_miso_oe, 1'b0);
    endtask

    task automatic t_wel();
        cmd1(8'h06);
        expect_status("R3 wren sets latch", 8'h02);
        cmd1(8'h04);
        expect_status("R3 wrdi clears latch", 8'h00);
    endtask

    task automatic t_stream();
        logic [7:0] b0, b1, b2;
        logic o;
        cmd1(8'h06);
        sel(); send_bits(8'h05, 8, o); recv_byte(b0); recv_byte(b1); recv_byte(b2); desel();
        chk("R2 stream byte0", b0, 8'h02);
        chk("R2 stream byte1", b1, 8'h02);
        chk("R2 stream byte2", b2, 8'h02);
        cmd1(8'h04);
    endtask

    task automatic t_boundary();
        logic o;
        int g0, d0;
        sel(); send_bits(8'h06, 7, o); desel();
        expect_status("R10 short opcode ignored", 8'h00);
        sel(); send_bits(8'h06, 8, o); send_bits(8'hFF, 3, o); desel();
        expect_status("R10 extra bits ignored", 8'h00);
        cmd1(8'h06);
        g0 = n_grant; d0 = n_deny;
        sel();
        send_bits(8'h02, 8, o); send_bits(8'h00, 8, o); send_bits(8'h00, 8, o);
        send_bits(8'h40, 8, o); send_bits(8'hA5, 8, o); send_bits(8'hA5, 4, o);
        desel();
        chk("R10 partial data no grant", n_grant - g0, 0);
        chk("R10 partial data no deny", n_deny - d0, 0);
        expect_status("R10 status kept", 8'h02);
        cmd1(8'h04);
    endtask

    task automatic t_nowel();
        int g0, d0;
        g0 = n_grant; d0 = n_deny;
        cmd_addr(8'h02, 24'h000010, 1);
        expect_decision("R11 pp without latch", g0, d0, 0, 1, 2'd0, 24'h000010);
        g0 = n_grant; d0 = n_deny;
        cmd_addr(8'hD8, 24'h001000, 0);
        expect_decision("R11 se without latch", g0, d0, 0, 1, 2'd1, 24'h001000);
        expect_status("R11 no busy after deny", 8'h00);
    endtask

    task automatic t_wrsr_busy();
        cmd2(8'h01, 8'h8C);
        expect_status("R4 write ignored without latch", 8'h00);
        cmd1(8'h06);
        cmd2(8'h01, 8'h0C);
        expect_status("R5 busy set after write", 8'h0F);
        cmd1(8'h04);
        expect_status("R6 wrdi ignored while busy", 8'h0F);
        wait_busy();
        expect_status("R4 R5 bits written busy and latch cleared", 8'h0C);
    endtask

    task automatic t_protect();
        int g0, d0;
        cmd1(8'h06);
        g0 = n_grant; d0 = n_deny;
        cmd_addr(8'h02, 24'h000100, 1);
        expect_decision("R7 bp11 all protected", g0, d0, 0, 1, 2'd0, 24'h000100);
        expect_status("R11 latch kept after deny", 8'h0E);
        cmd2(8'h01, 8'h04);
        wait_busy();
        expect_status("R4 bp set to 01", 8'h04);
        cmd1(8'h06);
        g0 = n_grant; d0 = n_deny;
        cmd_addr(8'hD8, 24'h030000, 0);
        expect_decision("R7 bp01 top quarter denied", g0, d0, 0, 1, 2'd1, 24'h030000);
        g0 = n_grant; d0 = n_deny;
        cmd_addr(8'hD8, 24'h02FFFF, 0);
        expect_decision("R7 bp01 below quarter granted", g0, d0, 1, 0, 2'd1, 24'h02FFFF);
        wait_busy();
        cmd1(8'h06);
        g0 = n_grant; d0 = n_deny;
        cmd1(8'hC7);
        expect_decision("R8 bulk erase denied with bp01", g0, d0, 0, 1, 2'd2, 24'h000000);
        cmd2(8'h01, 8'h08);
        wait_busy();
        cmd1(8'h06);
        g0 = n_grant; d0 = n_deny;
        cmd_addr(8'h02, 24'h020000, 2);
        expect_decision("R7 bp10 upper half denied", g0, d0, 0, 1, 2'd0, 24'h020000);
        g0 = n_grant; d0 = n_deny;
        cmd_addr(8'h02, 24'h01FFFF, 2);
        expect_decision("R7 bp10 lower half granted", g0, d0, 1, 0, 2'd0, 24'h01FFFF);
        wait_busy();
        cmd1(8'h06);
        cmd2(8'h01, 8'h00);
        wait_busy();
        cmd1(8'h06);
        g0 = n_grant; d0 = n_deny;
        cmd1(8'hC7);
        expect_decision("R8 bulk erase granted with bp00", g0, d0, 1, 0, 2'd2, 24'h000000);
        wait_busy();
        expect_status("R5 idle after bulk erase", 8'h00);
    endtask

    task automatic t_hpm();
        cmd1(8'h06);
        cmd2(8'h01, 8'h80);
        wait_busy();
        expect_status("R9 srwd set", 8'h80);
        wp_n = 1'b0;
        repeat (4) @(negedge clk);
        cmd1(8'h06);
        cmd2(8'h01, 8'h0C);
        expect_status("R9 write rejected when locked", 8'h82);
        wp_n = 1'b1;
        repeat (4) @(negedge clk);
        cmd2(8'h01, 8'h8C);
        wait_busy();
        expect_status("R9 write accepted with pin high", 8'h8C);
        cmd1(8'h06);
        cmd2(8'h01, 8'h00);
        wait_busy();
        expect_status("R9 cleared", 8'h00);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_wel();
        t_stream();
        t_boundary();
        t_nowel();
        t_wrsr_busy();
        t_protect();
        t_hpm();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule